// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block steps an analog-to-digital converter through each conversion. On a start request it works out which analog helpers the present configuration needs: the converter core, the programmable gain amplifier, the internal voltage reference, the temperature sensor path and the internal DAC path. It powers them and waits until the slowest of them has settled. It then times the sampling window and a fixed-length conversion phase. The helpers start up in parallel, so the wait is the longest start-up time among only those that actually have to start. Times are given in microseconds and scaled to clock cycles by a parameter.

In low-latency mode the block keeps the configured helpers powered between conversions. A later start then waits only for helpers that the new configuration adds, or for a short settle when the selected internal reference changes. With free-run set, each conversion end at once counts as a new start. The configuration is captured when a conversion starts. A start request that arrives while the sequencer is occupied is dropped and reported with a one-cycle pulse.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `modEn`, `busy`, `initBusy`, `sampleStrobe`, `halfEnd`, `convStrobe` and `overrun` are all low.
- R2: The settling wait in cycles is the largest time among the helpers to be started, with CLK_PER_US cycles per microsecond: core 10 µs, amplifier 20 µs, internal reference 60 µs, temperature path 35 µs, DAC path 35 µs. The `modEn` bits are 0 core, 1 amplifier, 2 reference, 3 temperature, 4 DAC. The core is always required. The amplifier is required when `pgaEn` is 1. The reference is required when `refSel` is 1 or 2. The temperature path is required when `srcSel` is 1, and the DAC path when `srcSel` is 2.
- R3: With SLOW_CLK set, the core start-up time is 20 clock cycles instead of 10 µs.
- R4: In low-latency mode, the required helpers stay powered after a conversion. A repeated start with the same configuration has no wait, and sampling begins in the cycle after the start is captured.
- R5: In low-latency mode, a start waits only for helpers that were not already powered. If the reference was powered and `refSel` changes between the two internal codes, the wait includes 2 µs. Helpers that the new configuration does not need are switched off.
- R6: Outside low-latency mode, all helpers are switched off when a conversion ends, and every start waits the full time for its configuration.
- R7: `busy` is high from the cycle after a start is captured until the last conversion cycle. `initBusy` is high exactly for the wait cycles.
- R8: The sampling window lasts sampDur+1 cycles, and `sampleStrobe` marks its last cycle. `halfEnd` is high together with `sampleStrobe` when the amplifier is off, which asks for the hold at mid-cycle (sampDur+½), and it stays low when the amplifier is on.
- R9: The conversion phase lasts CONV_CYCLES cycles after the window. `convStrobe` marks its last cycle.
- R10: With `freeRun` high, the cycle after `convStrobe` already belongs to the next conversion. In low-latency mode with no new helpers, that cycle is sampling; otherwise it is settling.
- R11: A start request while `busy` is ignored, and `overrun` is high for the one following cycle.
- R12: The configuration is captured at the start. Changes during a conversion do not alter `modEn`, the window length or `halfEnd` of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcSel | input | 2 | Input select: 0/3 external, 1 temperature, 2 DAC |
| refSel | input | 2 | Reference select: 0 supply, 1 and 2 internal, 3 external |
| pgaEn | input | 1 | Use the gain amplifier |
| lowLat | input | 1 | Keep helpers powered between conversions |
| sampDur | input | SAMP_W | Sampling duration setting |
| freeRun | input | 1 | Restart right after each conversion |
| startReq | input | 1 | Start a conversion |
| modEn | output | 5 | Helper power enables |
| busy | output | 1 | Sequence in progress |
| initBusy | output | 1 | Settling wait in progress |
| sampleStrobe | output | 1 | Last cycle of the sampling window |
| halfEnd | output | 1 | Hold at mid-cycle of the strobe cycle |
| convStrobe | output | 1 | Last cycle of the conversion |
| overrun | output | 1 | A start request was dropped |

## Verification
The assertions check on every cycle that the helper enables stay frozen while a conversion runs, that settling only happens while busy, that at most one of the settling flag and the two strobes is high, that a conversion phase follows every sampling strobe, that helpers drop after a conversion outside low-latency mode, that the counter never counts below zero, and that an overrun pulse follows a busy cycle. The exact wait lengths for each mix of helpers, the savings of low-latency mode, the short reference switch, free-run chaining and the capture of the configuration depend on the history of stimuli, so only the directed scenarios show them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NMOD   = 5;
  localparam int M_CORE = 0;
  localparam int M_PGA  = 1;
  localparam int M_REF  = 2;
  localparam int M_TEMP = 3;
  localparam int M_DAC  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_SAMP, ST_CONV} seqState_t;

  typedef struct packed {
    logic ldInit;
    logic ldSamp;
    logic ldConv;
    logic dec;
  } ctlStrb_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer
  import adc_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter bit SLOW_CLK    = 1'b0,
  parameter int SAMP_W      = 8,
  parameter int CONV_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrb_t          strb,
  input  logic [NMOD-1:0]   newSet,
  input  logic              refSw,
  input  logic [SAMP_W-1:0] sampUse,
  output logic              cntZero,
  output logic              waitZero
);
  localparam int T_CORE = SLOW_CLK ? 20 : 10 * CLK_PER_US;
  localparam int T_REF  = 60 * CLK_PER_US;
  localparam int T_RSW  = 2 * CLK_PER_US;
  localparam int T_TOP  = (T_REF > T_CORE) ? T_REF : T_CORE;
  localparam int S_TOP  = (2 ** SAMP_W) - 1;
  localparam int A_TOP  = (T_TOP > S_TOP) ? T_TOP : S_TOP;
  localparam int C_TOP  = (A_TOP > CONV_CYCLES) ? A_TOP : CONV_CYCLES;
  localparam int CNT_W  = $clog2(C_TOP + 1);

  function automatic int modTime(input int idx);
    case (idx)
      M_CORE:  return T_CORE;
      M_PGA:   return 20 * CLK_PER_US;
      M_REF:   return T_REF;
      default: return 35 * CLK_PER_US;
    endcase
  endfunction

  logic [CNT_W-1:0] cand [NMOD+1];
  logic [CNT_W-1:0] waitCyc;
  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < NMOD; i++) begin : g_cand
    assign cand[i] = newSet[i] ? CNT_W'(modTime(i)) : '0;
  end
  assign cand[NMOD] = refSw ? CNT_W'(T_RSW) : '0;

  always_comb begin
    waitCyc = '0;
    for (int i = 0; i <= NMOD; i++)
      if (cand[i] > waitCyc) waitCyc = cand[i];
  end

  assign waitZero = (waitCyc == '0);
  assign cntZero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (strb.ldInit) cnt <= waitCyc - 1'b1;
    else if (strb.ldSamp) cnt <= CNT_W'(sampUse);
    else if (strb.ldConv) cnt <= CNT_W'(CONV_CYCLES - 1);
    else if (strb.dec)    cnt <= cnt - 1'b1;
  end

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dec |-> !cntZero);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        srcSel,
  input  logic [1:0]        refSel,
  input  logic              pgaEn,
  input  logic              lowLat,
  input  logic [SAMP_W-1:0] sampDur,
  input  logic              freeRun,
  input  logic              startReq,
  input  logic              cntZero,
  input  logic              waitZero,
  output ctlStrb_t          strb,
  output logic [NMOD-1:0]   newSet,
  output logic              refSw,
  output logic [SAMP_W-1:0] sampUse,
  output logic [NMOD-1:0]   modEn,
  output logic              busy,
  output logic              initBusy,
  output logic              sampleStrobe,
  output logic              halfEnd,
  output logic              convStrobe,
  output logic              overrun
);
  seqState_t         state, stateN;
  logic [NMOD-1:0]   pwrOn, reqSet, keepSet;
  logic [1:0]        lastRef;
  logic              pgaQ;
  logic [SAMP_W-1:0] sampQ;
  logic              convEnd, startNow, refInt;

  assign refInt = (refSel == 2'd1) || (refSel == 2'd2);

  always_comb begin
    reqSet         = '0;
    reqSet[M_CORE] = 1'b1;
    reqSet[M_PGA]  = pgaEn;
    reqSet[M_REF]  = refInt;
    reqSet[M_TEMP] = (srcSel == 2'd1);
    reqSet[M_DAC]  = (srcSel == 2'd2);
  end

  assign keepSet  = lowLat ? pwrOn : '0;
  assign newSet   = reqSet & ~keepSet;
  assign refSw    = lowLat && refInt && pwrOn[M_REF] && (refSel != lastRef);
  assign convEnd  = (state == ST_CONV) && cntZero;
  assign startNow = ((state == ST_IDLE) && startReq) || (convEnd && freeRun);
  assign sampUse  = startNow ? sampDur : sampQ;

  always_comb begin
    strb   = '0;
    stateN = state;
    if (startNow) begin
      if (waitZero) begin strb.ldSamp = 1'b1; stateN = ST_SAMP; end
      else          begin strb.ldInit = 1'b1; stateN = ST_INIT; end
    end else begin
      case (state)
        ST_INIT: if (cntZero) begin strb.ldSamp = 1'b1; stateN = ST_SAMP; end
                 else strb.dec = 1'b1;
        ST_SAMP: if (cntZero) begin strb.ldConv = 1'b1; stateN = ST_CONV; end
                 else strb.dec = 1'b1;
        ST_CONV: if (cntZero) stateN = ST_IDLE;
                 else strb.dec = 1'b1;
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pwrOn   <= '0;
      lastRef <= '0;
      pgaQ    <= 1'b0;
      sampQ   <= '0;
      overrun <= 1'b0;
    end else begin
      state   <= stateN;
      overrun <= startReq && (state != ST_IDLE);
      if (startNow) begin
        pwrOn   <= reqSet;
        lastRef <= refSel;
        pgaQ    <= pgaEn;
        sampQ   <= sampDur;
      end else if ((convEnd || state == ST_IDLE) && !lowLat) begin
        pwrOn <= '0;
      end
    end
  end

  assign modEn        = pwrOn;
  assign busy         = (state != ST_IDLE);
  assign initBusy     = (state == ST_INIT);
  assign sampleStrobe = (state == ST_SAMP) && cntZero;
  assign convStrobe   = convEnd;
  assign halfEnd      = sampleStrobe && !pgaQ;

  // R7
  init_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initBusy |-> busy);
  // R9
  conv_after_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |=> (busy && !initBusy && !sampleStrobe));
  // R8
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({initBusy, sampleStrobe, convStrobe}));
  // R6
  power_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (convStrobe && !lowLat && !freeRun) |=> (modEn == '0));
  // R12
  en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !convStrobe) |=> $stable(modEn));
  // R11
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy));
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter bit SLOW_CLK    = 1'b0,
  parameter int SAMP_W      = 8,
  parameter int CONV_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        srcSel,
  input  logic [1:0]        refSel,
  input  logic              pgaEn,
  input  logic              lowLat,
  input  logic [SAMP_W-1:0] sampDur,
  input  logic              freeRun,
  input  logic              startReq,
  output logic [4:0]        modEn,
  output logic              busy,
  output logic              initBusy,
  output logic              sampleStrobe,
  output logic              halfEnd,
  output logic              convStrobe,
  output logic              overrun
);
  ctlStrb_t          strb;
  logic [NMOD-1:0]   newSet;
  logic              refSw, cntZero, waitZero;
  logic [SAMP_W-1:0] sampUse;

  seq_ctrl #(.SAMP_W(SAMP_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .refSel(refSel),
    .pgaEn(pgaEn), .lowLat(lowLat), .sampDur(sampDur), .freeRun(freeRun),
    .startReq(startReq), .cntZero(cntZero), .waitZero(waitZero),
    .strb(strb), .newSet(newSet), .refSw(refSw), .sampUse(sampUse),
    .modEn(modEn), .busy(busy), .initBusy(initBusy),
    .sampleStrobe(sampleStrobe), .halfEnd(halfEnd),
    .convStrobe(convStrobe), .overrun(overrun)
  );

  seq_timer #(
    .CLK_PER_US(CLK_PER_US), .SLOW_CLK(SLOW_CLK),
    .SAMP_W(SAMP_W), .CONV_CYCLES(CONV_CYCLES)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .newSet(newSet), .refSw(refSw),
    .sampUse(sampUse), .cntZero(cntZero), .waitZero(waitZero)
  );
endmodule

// File: tb/adc_start_seq_tb.sv
`timescale 1ns/1ps
module adc_start_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] srcSel = '0, refSel = '0;
  logic pgaEn = 1'b0, lowLat = 1'b0, freeRun = 1'b0;
  logic startReq = 1'b0, sStart = 1'b0;
  logic [7:0] sampDur = '0;
  logic [4:0] modEn, sModEn;
  logic busy, initBusy, sampleStrobe, halfEnd, convStrobe, overrun;
  logic sBusy, sInit, sSamp, sHalf, sConv, sOver;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  adc_start_seq dut_i (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .refSel(refSel), .pgaEn(pgaEn),
    .lowLat(lowLat), .sampDur(sampDur), .freeRun(freeRun), .startReq(startReq),
    .modEn(modEn), .busy(busy), .initBusy(initBusy), .sampleStrobe(sampleStrobe),
    .halfEnd(halfEnd), .convStrobe(convStrobe), .overrun(overrun));

  adc_start_seq #(.CLK_PER_US(1), .SLOW_CLK(1'b1)) slow_i (
    .clk(clk), .rst_n(rst_n), .srcSel(srcSel), .refSel(refSel), .pgaEn(pgaEn),
    .lowLat(lowLat), .sampDur(sampDur), .freeRun(1'b0), .startReq(sStart),
    .modEn(sModEn), .busy(sBusy), .initBusy(sInit), .sampleStrobe(sSamp),
    .halfEnd(sHalf), .convStrobe(sConv), .overrun(sOver));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int s, input int r, input bit p, input bit ll, input int sd);
    @(negedge clk);
    srcSel = 2'(s); refSel = 2'(r); pgaEn = p; lowLat = ll; sampDur = 8'(sd);
  endtask

  task automatic runConv(input bit perturb, output int ini, output int samp,
                         output int conv, output int he, output int en, output int enEnd);
    int ph;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    ini = 0; samp = 0; conv = 0; he = -1; ph = 0; en = modEn; enEnd = -1;
    if (perturb) begin pgaEn = 1'b1; srcSel = 2'd1; sampDur = 8'd1; end
    for (int k = 0; k < 5000; k++) begin
      if (ph == 0 && initBusy) ini++;
      else if (ph == 0) begin
        samp++;
        if (sampleStrobe) begin ph = 1; he = halfEnd; end
      end else begin
        conv++;
        if (convStrobe) begin enEnd = modEn; break; end
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 modEn", modEn, 0);
    chk("R1 busy", busy, 0);
    chk("R1 initBusy", initBusy, 0);
    chk("R1 strobes", {sampleStrobe, halfEnd, convStrobe}, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_plain;
    int i, s, c, h, e, ee;
    setCfg(0, 0, 0, 0, 5);
    runConv(0, i, s, c, h, e, ee);
    chk("R2 core wait", i, 40);
    chk("R2 core enable", e, 5'b00001);
    chk("R8 window", s, 6);
    chk("R8 halfEnd no amp", h, 1);
    chk("R9 conv length", c, 13);
    @(negedge clk);
    chk("R6 off after end", modEn, 0);
    chk("R7 busy ends", busy, 0);
  endtask

  task automatic t_mix;
    int i, s, c, h, e, ee;
    setCfg(1, 1, 1, 0, 9);
    runConv(0, i, s, c, h, e, ee);
    chk("R2 ref wait", i, 240);
    chk("R2 full enable", e, 5'b01111);
    chk("R8 window amp", s, 10);
    chk("R8 halfEnd amp", h, 0);
    setCfg(1, 0, 0, 0, 3);
    runConv(0, i, s, c, h, e, ee);
    chk("R2 temp wait", i, 140);
    chk("R2 temp enable", e, 5'b01001);
    runConv(0, i, s, c, h, e, ee);
    chk("R6 repeat full wait", i, 140);
    setCfg(2, 0, 0, 0, 3);
    runConv(0, i, s, c, h, e, ee);
    chk("R2 dac wait", i, 140);
    chk("R2 dac enable", e, 5'b10001);
  endtask

  task automatic t_lowlat;
    int i, s, c, h, e, ee;
    setCfg(0, 0, 0, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R4 first wait", i, 40);
    @(negedge clk);
    chk("R4 kept powered", modEn, 5'b00001);
    runConv(0, i, s, c, h, e, ee);
    chk("R4 no wait", i, 0);
    chk("R4 window", s, 5);
    setCfg(0, 0, 1, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 amp only", i, 80);
    setCfg(0, 1, 1, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 ref new", i, 240);
    setCfg(0, 2, 1, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 ref switch", i, 8);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 same ref", i, 0);
    setCfg(2, 2, 1, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 dac new", i, 140);
    chk("R5 dac enable", e, 5'b10111);
    setCfg(0, 2, 0, 1, 4);
    runConv(0, i, s, c, h, e, ee);
    chk("R5 drop wait", i, 0);
    chk("R5 drop enable", e, 5'b00101);
  endtask

  task automatic t_overrun;
    int n;
    setCfg(0, 0, 0, 0, 5);
    repeat (2) @(negedge clk);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 4) startReq = 1'b1;
      if (n == 5) begin startReq = 1'b0; chk("R11 pulse", overrun, 1); end
      if (n == 6) chk("R11 one cycle", overrun, 0);
      @(negedge clk);
    end
    chk("R11 request ignored", n, 59);
    chk("R7 busy span", busy, 0);
  endtask

  task automatic t_freerun;
    int i, s, c, h, e, ee, n;
    setCfg(0, 0, 0, 1, 2);
    freeRun = 1'b1;
    runConv(0, i, s, c, h, e, ee);
    chk("R10 first wait", i, 40);
    @(negedge clk);
    chk("R10 chained busy", busy, 1);
    chk("R10 chained no wait", initBusy, 0);
    freeRun = 1'b0;
    n = 1;
    while (!sampleStrobe && n < 100) begin @(negedge clk); n++; end
    chk("R10 chained window", n, 3);
    while (busy) @(negedge clk);
    setCfg(0, 0, 0, 0, 2);
    freeRun = 1'b1;
    runConv(0, i, s, c, h, e, ee);
    @(negedge clk);
    chk("R10 chained settle", initBusy, 1);
    chk("R10 chained enable", modEn, 5'b00001);
    freeRun = 1'b0;
    n = 0;
    while (initBusy && n < 1000) begin n++; @(negedge clk); end
    chk("R10 chained wait", n, 40);
    while (busy) @(negedge clk);
  endtask

  task automatic t_capture;
    int i, s, c, h, e, ee;
    setCfg(0, 0, 0, 0, 7);
    runConv(1, i, s, c, h, e, ee);
    chk("R12 wait", i, 40);
    chk("R12 window", s, 8);
    chk("R12 halfEnd", h, 1);
    chk("R12 enable held", ee, 5'b00001);
  endtask

  task automatic t_slow;
    int n;
    setCfg(0, 0, 0, 0, 3);
    @(negedge clk) sStart = 1'b1;
    @(negedge clk) sStart = 1'b0;
    n = 0;
    while (sInit && n < 1000) begin n++; @(negedge clk); end
    chk("R3 slow core", n, 20);
    while (sBusy) @(negedge clk);
    setCfg(0, 1, 0, 0, 3);
    @(negedge clk) sStart = 1'b1;
    @(negedge clk) sStart = 1'b0;
    n = 0;
    while (sInit && n < 1000) begin n++; @(negedge clk); end
    chk("R3 slow ref", n, 60);
    while (sBusy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_mix();
    t_lowlat();
    t_overrun();
    t_freerun();
    t_capture();
    t_slow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule